// File: doc/BRIEF.md
# Four-Lane Three-Wire Receive Symbol Aligner

This block is the digital front end of a four-lane receiver for a three-wire, embedded-clock serial link. Each lane delivers 3-bit symbols together with the clock recovered from that lane's own symbol stream. That recovered clock is used directly as the lane's capture clock. A small dual-clock symbol FIFO on each lane carries the symbols into one common clock domain. On the common side, a per-lane hunter discards line symbols until it sees a programmable sync word. The lanes are then released together, so the payload of all active lanes leaves in lockstep as one wide beat per cycle.

A controller on the common clock moves between low-power receive and high-speed receive. It uses the enable input, the per-lane enables and the stop-state indication from the line. When a burst begins, it waits a programmed settle time and then hunts for sync under a programmed timeout. It delivers aligned payload until the line returns to its stop state. It then flushes the FIFOs and re-arms the hunters.

The payload output is a valid/ready stream. A beat, once offered, stays unchanged until it is accepted. The lanes cannot be stalled, so while `out_ready` is low the symbols collect in the lane FIFOs. A stall longer than the FIFO headroom loses symbols at the write side.

Top module: `cphy_rx_align`

## Requirements
- R1: After reset, `lp_rx` is 1, and `hs_locked`, `sync_err` and `out_valid` are 0.
- R2: A burst starts only on a clock where `lp_stop` is sampled low after being high on the previous clock, with `hs_rx_en` high and `lane_en` non-zero. `lane_en` is captured at that moment. Holding `lp_stop` low, or starting while `hs_rx_en` is low, leaves the block in low-power receive.
- R3: For the first `cfg_settle`+1 cycles of a burst, symbols arriving on the lanes are discarded and cannot produce a sync match.
- R4: Each active lane looks for a sync word of 7 symbols. The first symbol on the line corresponds to `cfg_sync_word[20:18]` and the last to `cfg_sync_word[2:0]`. Symbols before the word are dropped, and the symbol right after it is that lane's first payload symbol.
- R5: Beat k on `out_sym` carries the k-th payload symbol of lane i in bits [3i+2:3i], whatever the arrival skew between lanes, as long as the skew fits the FIFO headroom.
- R6: Lanes that were not enabled at burst start read as 0 in `out_sym`. Their line activity has no effect.
- R7: Once the last active lane has consumed its final sync symbol, `hs_locked` is high on the next clock, and the first aligned beat is offered within two clocks.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_sym` is held. Payload held back by a stall is delivered complete and in order after it.
- R9: If not every active lane has found sync, `sync_err` rises on the rising edge numbered `cfg_settle`+`cfg_sync_timeout`+3, counting the edge that starts the burst as edge 1. At that point the block is back in low-power receive. `sync_err` stays set until the next burst starts.
- R10: `lp_stop` high or `hs_rx_en` low during a burst returns the block to low-power receive on the next clock, with `out_valid` low. Undelivered symbols are discarded, so the next burst delivers only its own payload.
- R11: The sync word is taken from `cfg_sync_word`. A line that carries any other 7-symbol word does not lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for control, hunting and output |
| rst_n | input | 1 | Active-low asynchronous reset |
| hs_rx_en | input | 1 | Allows high-speed receive bursts |
| lp_stop | input | 1 | Line in stop state (all lanes at low-power high) |
| lane_en | input | 4 | Lanes taking part in the next burst |
| cfg_settle | input | 8 | Settle duration in cycles, minus one |
| cfg_sync_timeout | input | 12 | Sync hunt limit in cycles |
| cfg_sync_word | input | 21 | Seven-symbol sync word, first symbol in top bits |
| lane_clk | input | 4 | Recovered clock of each lane |
| lane_sym | input | 12 | Symbol of each lane, 3 bits per lane |
| lane_sym_vld | input | 4 | Symbol strobe of each lane in its own clock |
| out_valid | output | 1 | Aligned beat available |
| out_ready | input | 1 | Consumer accepts the beat |
| out_sym | output | 12 | Aligned beat, 3 bits per lane |
| lp_rx | output | 1 | Block is in low-power receive |
| hs_locked | output | 1 | All active lanes aligned, payload phase |
| sync_err | output | 1 | Last burst failed to find sync in time |

## Verification
The alignment is tried with four kinds of pattern:
- Equal lane timing with no leading line noise shows basic framing.
- Unequal start delays mixed with different amounts of leading noise separate true deskew from lucky timing.
- A partial lane mask, with the masked lanes still toggling, shows that the idle lanes are really ignored.
- A sync word changed away from the one on the line shows that the match follows the configuration.

Failure paths are distinguished by when and how they fail. A sync word hidden inside the settle window, a lane that stays silent, and a long output stall ended by a stop-state return each have a separate expected outcome. The timeout case is checked to the exact clock edge.

// File: rtl/cphy_rx_pkg.sv
package cphy_rx_pkg;
  localparam int SYM_W = 3;

  typedef enum logic [1:0] {
    ST_LP     = 2'd0,
    ST_SETTLE = 2'd1,
    ST_HUNT   = 2'd2,
    ST_DATA   = 2'd3
  } rx_state_e;
endpackage

// File: rtl/cphy_lane_fifo.sv
// Dual-clock symbol FIFO: written in the lane's recovered clock,
// read and flushed in the common clock. Gray pointers, two-flop sync.
module cphy_lane_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 3
) (
  input  logic         rst_n,
  // lane side
  input  logic         wclk,
  input  logic         cap_en,     // common-domain level, synced here
  input  logic [W-1:0] din,
  input  logic         din_vld,
  // common side
  input  logic         clk,
  input  logic         flush,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [W-1:0] mem [DEPTH];
  logic [1:0]   cap_s;
  logic [AW:0]  wbin, wgray, wbin_nx, rg_s1, rg_s2;
  logic [AW:0]  rbin, rgray, rbin_nx, wg_s1, wg_s2;
  logic         full, wr;

  // ---------------- write side (lane clock) ----------------
  assign wbin_nx = wbin + (AW+1)'(1);
  assign full    = (wgray == {~rg_s2[AW:AW-1], rg_s2[AW-2:0]});
  assign wr      = cap_s[1] & din_vld & ~full;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      cap_s <= '0;
      wbin  <= '0;
      wgray <= '0;
      rg_s1 <= '0;
      rg_s2 <= '0;
    end else begin
      cap_s <= {cap_s[0], cap_en};
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (wr) begin
        wbin  <= wbin_nx;
        wgray <= (wbin_nx >> 1) ^ wbin_nx;
      end
    end
  end

  always_ff @(posedge wclk) begin
    if (wr) mem[wbin[AW-1:0]] <= din;
  end

  // ---------------- read side (common clock) ----------------
  assign rbin_nx = rbin + (AW+1)'(1);
  assign empty   = (rgray == wg_s2);
  assign dout    = mem[rbin[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
      wg_s1 <= '0;
      wg_s2 <= '0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      if (flush) begin
        rbin  <= g2b(wg_s2);
        rgray <= wg_s2;
      end else if (pop) begin
        rbin  <= rbin_nx;
        rgray <= (rbin_nx >> 1) ^ rbin_nx;
      end
    end
  end

  // R5: the aligner never reads a symbol that has not crossed yet
  p_pop_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/cphy_sync_hunt.sv
// Per-lane sync hunter in the common domain: consumes symbols until the
// last SYNC_SYMS symbols equal the pattern, then stops and holds found.
module cphy_sync_hunt #(
  parameter int SYNC_SYMS = 7,
  parameter int W         = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   arm,
  input  logic                   avail,
  input  logic [W-1:0]           sym,
  input  logic [SYNC_SYMS*W-1:0] pattern,
  output logic                   pop,
  output logic                   found
);
  localparam int HW  = (SYNC_SYMS - 1) * W;
  localparam int FCW = $clog2(SYNC_SYMS);

  logic [HW-1:0]          hist;
  logic [FCW-1:0]         fill;
  logic [SYNC_SYMS*W-1:0] cand;
  logic                   win_full, hit;

  assign cand     = {hist, sym};
  assign win_full = (fill == FCW'(SYNC_SYMS - 1));
  assign hit      = win_full && (cand == pattern);
  assign pop      = arm & ~found & avail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist  <= '0;
      fill  <= '0;
      found <= 1'b0;
    end else if (clr) begin
      hist  <= '0;
      fill  <= '0;
      found <= 1'b0;
    end else if (pop) begin
      hist <= cand[HW-1:0];
      if (!win_full) fill <= fill + FCW'(1);
      if (hit) found <= 1'b1;
    end
  end

  // R4: once a lane has seen its sync word it keeps it for the burst
  p_found_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (found && !clr) |=> found);
endmodule

// File: rtl/cphy_rx_ctrl.sv
// Receive mode controller: low-power receive, settle, sync hunt, payload.
module cphy_rx_ctrl
  import cphy_rx_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int SETTLE_W = 8,
  parameter int TMO_W    = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hs_rx_en,
  input  logic                lp_stop,
  input  logic [LANES-1:0]    lane_en,
  input  logic [SETTLE_W-1:0] cfg_settle,
  input  logic [TMO_W-1:0]    cfg_timeout,
  input  logic                all_found,
  output rx_state_e           st,
  output logic [LANES-1:0]    active,
  output logic                sync_err
);
  localparam int CW = (SETTLE_W > TMO_W) ? SETTLE_W : TMO_W;

  logic          lp_stop_q, start, stop;
  logic [CW-1:0] cnt;

  assign start = (st == ST_LP) && lp_stop_q && !lp_stop && hs_rx_en && (|lane_en);
  assign stop  = lp_stop || !hs_rx_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_LP;
      cnt       <= '0;
      active    <= '0;
      sync_err  <= 1'b0;
      lp_stop_q <= 1'b1;
    end else begin
      lp_stop_q <= lp_stop;
      unique case (st)
        ST_LP: if (start) begin
          st       <= ST_SETTLE;
          cnt      <= '0;
          active   <= lane_en;
          sync_err <= 1'b0;
        end
        ST_SETTLE: begin
          if (stop) st <= ST_LP;
          else if (cnt == CW'(cfg_settle)) begin
            st  <= ST_HUNT;
            cnt <= '0;
          end else cnt <= cnt + CW'(1);
        end
        ST_HUNT: begin
          if (stop) st <= ST_LP;
          else if (all_found) st <= ST_DATA;
          else if (cnt == CW'(cfg_timeout)) begin
            st       <= ST_LP;
            sync_err <= 1'b1;
          end else cnt <= cnt + CW'(1);
        end
        ST_DATA: if (stop) st <= ST_LP;
        default: st <= ST_LP;
      endcase
    end
  end

  // R7: every active lane aligned -> payload phase on the next clock
  p_lock_fast_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HUNT && all_found && !stop) |=> (st == ST_DATA));
  // R9: a sync failure always lands in low-power receive
  p_err_lp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_err) |-> (st == ST_LP));
  // R2: the lane mask captured at burst start does not move during it
  p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_LP) |=> (st == ST_LP || $stable(active)));
endmodule

// File: rtl/cphy_rx_align.sv
module cphy_rx_align
  import cphy_rx_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int SYNC_SYMS  = 7,
  parameter int FIFO_DEPTH = 16,
  parameter int SETTLE_W   = 8,
  parameter int TMO_W      = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         hs_rx_en,
  input  logic                         lp_stop,
  input  logic [LANES-1:0]             lane_en,
  input  logic [SETTLE_W-1:0]          cfg_settle,
  input  logic [TMO_W-1:0]             cfg_sync_timeout,
  input  logic [SYNC_SYMS*SYM_W-1:0]   cfg_sync_word,
  input  logic [LANES-1:0]             lane_clk,
  input  logic [LANES*SYM_W-1:0]       lane_sym,
  input  logic [LANES-1:0]             lane_sym_vld,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [LANES*SYM_W-1:0]       out_sym,
  output logic                         lp_rx,
  output logic                         hs_locked,
  output logic                         sync_err
);
  localparam int W = SYM_W;

  rx_state_e        st;
  logic [LANES-1:0] active, found, avail, hpop, pop;
  logic             all_found, cap_on, fire;

  assign all_found = &(found | ~active);
  assign cap_on    = (st == ST_HUNT) || (st == ST_DATA);
  assign lp_rx     = (st == ST_LP);
  assign hs_locked = (st == ST_DATA);
  assign out_valid = hs_locked && (&(avail | ~active));
  assign fire      = out_valid && out_ready;

  cphy_rx_ctrl #(
    .LANES(LANES), .SETTLE_W(SETTLE_W), .TMO_W(TMO_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .hs_rx_en(hs_rx_en), .lp_stop(lp_stop),
    .lane_en(lane_en), .cfg_settle(cfg_settle), .cfg_timeout(cfg_sync_timeout),
    .all_found(all_found), .st(st), .active(active), .sync_err(sync_err)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [W-1:0] head;
    logic         empty;

    assign avail[i] = ~empty;
    assign pop[i]   = active[i] & (hpop[i] | fire);
    assign out_sym[i*W +: W] = active[i] ? head : '0;

    cphy_lane_fifo #(.DEPTH(FIFO_DEPTH), .W(W)) u_fifo (
      .rst_n(rst_n), .wclk(lane_clk[i]), .cap_en(cap_on & active[i]),
      .din(lane_sym[i*W +: W]), .din_vld(lane_sym_vld[i]),
      .clk(clk), .flush(~cap_on), .pop(pop[i]), .dout(head), .empty(empty)
    );

    cphy_sync_hunt #(.SYNC_SYMS(SYNC_SYMS), .W(W)) u_hunt (
      .clk(clk), .rst_n(rst_n), .clr(~cap_on),
      .arm((st == ST_HUNT) & active[i]), .avail(~empty), .sym(head),
      .pattern(cfg_sync_word), .pop(hpop[i]), .found(found[i])
    );
  end

  // R8: an offered beat is held until taken
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !lp_stop && hs_rx_en) |=> (out_valid && $stable(out_sym)));
  // R10: stop state during payload ends the burst on the next clock
  p_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_locked && lp_stop) |=> (lp_rx && !out_valid));
endmodule

// File: tb/sim_cphy_rx_align.sv
module sim_cphy_rx_align;
  logic        clk, rst_n, hs_rx_en, lp_stop, out_ready;
  logic [3:0]  lane_en, lane_clk, lane_sym_vld;
  logic [7:0]  cfg_settle;
  logic [11:0] cfg_sync_timeout;
  logic [20:0] cfg_sync_word;
  logic [11:0] lane_sym, out_sym;
  logic        out_valid, lp_rx, hs_locked, sync_err;

  localparam logic [20:0] WORD_A = 21'b011_100_100_100_100_100_100;
  localparam logic [20:0] WORD_B = 21'b000_001_010_011_100_000_001;

  int n_chk = 0, n_err = 0, go_cnt = 0, cyc = 0, hold_until = 0, got_n = 0;
  bit done = 0;
  logic [2:0]  tx_sym [4][32];
  int          tx_len [4];
  int          tx_dly [4];
  logic [11:0] got [256];

  cphy_rx_align u0 (
    .clk(clk), .rst_n(rst_n), .hs_rx_en(hs_rx_en), .lp_stop(lp_stop),
    .lane_en(lane_en), .cfg_settle(cfg_settle), .cfg_sync_timeout(cfg_sync_timeout),
    .cfg_sync_word(cfg_sync_word), .lane_clk(lane_clk), .lane_sym(lane_sym),
    .lane_sym_vld(lane_sym_vld), .out_valid(out_valid), .out_ready(out_ready),
    .out_sym(out_sym), .lp_rx(lp_rx), .hs_locked(hs_locked), .sync_err(sync_err)
  );

  initial begin clk = 0; forever #5 clk = ~clk; end

  // lane transmitters, each on its own recovered clock phase
  for (genvar g = 0; g < 4; g++) begin : g_drv
    logic c, v;
    logic [2:0] s;
    assign lane_clk[g] = c;
    assign lane_sym[g*3 +: 3] = s;
    assign lane_sym_vld[g] = v;
    initial begin c = 0; #(1 + 2*g); forever #5 c = ~c; end
    initial begin
      int seen;
      seen = 0; s = '0; v = 0;
      forever begin
        wait (go_cnt != seen);
        seen = go_cnt;
        repeat (tx_dly[g]) @(negedge c);
        for (int k = 0; k < tx_len[g]; k++) begin
          @(negedge c); s = tx_sym[g][k]; v = 1;
        end
        @(negedge c); v = 0;
      end
    end
  end

  // output sink: ready decided first, then the beat taken at the next edge is logged
  always @(negedge clk) begin
    logic r;
    cyc = cyc + 1;
    r = (cyc >= hold_until);
    out_ready = r;
    if (out_valid && r && got_n < 256) begin
      got[got_n] = out_sym;
      got_n = got_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] pay(int l, int base, int k);
    return 3'((base + l*5 + k*3) % 8);
  endfunction

  function automatic logic [11:0] exp_beat(logic [3:0] mask, int base, int k);
    logic [11:0] b = '0;
    for (int l = 0; l < 4; l++) if (mask[l]) b[l*3 +: 3] = pay(l, base, k);
    return b;
  endfunction

  task automatic load_lane(int l, int junk, int npay, int base, int dly, logic [20:0] word);
    int i = 0;
    for (int j = 0; j < junk; j++) begin tx_sym[l][i] = (j % 2) ? 3'd2 : 3'd1; i++; end
    for (int j = 0; j < 7; j++) begin tx_sym[l][i] = word[20-3*j -: 3]; i++; end
    for (int k = 0; k < npay; k++) begin tx_sym[l][i] = pay(l, base, k); i++; end
    tx_len[l] = i;
    tx_dly[l] = dly;
  endtask

  task automatic check_beats(int start, int n, logic [3:0] mask, int base, string req);
    chk(got_n - start == n, req, "beat count", got_n - start, n);
    for (int k = 0; k < n && start + k < got_n; k++)
      chk(got[start+k] == exp_beat(mask, base, k), req, "beat data",
          got[start+k], exp_beat(mask, base, k));
  endtask

  task automatic begin_burst(logic [3:0] mask);
    @(negedge clk); lane_en = mask; lp_stop = 0;
    repeat (int'(cfg_settle) + 10) @(negedge clk);
    go_cnt++;
  endtask

  task automatic end_burst();
    @(negedge clk); lp_stop = 1;
    repeat (20) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(lp_rx == 1, "R1", "lp_rx", lp_rx, 1);
    chk(hs_locked == 0, "R1", "hs_locked", hs_locked, 0);
    chk(sync_err == 0, "R1", "sync_err", sync_err, 0);
    chk(out_valid == 0, "R1", "out_valid", out_valid, 0);
  endtask

  task automatic t_basic();  // R4 R5
    int st = got_n;
    for (int l = 0; l < 4; l++) load_lane(l, 0, 8, 1, 0, WORD_A);
    begin_burst(4'hF);
    repeat (80) @(negedge clk);
    chk(hs_locked == 1, "R4", "locked after sync", hs_locked, 1);
    check_beats(st, 8, 4'hF, 1, "R5");
    end_burst();
  endtask

  task automatic t_skew();  // R4 R5 R7
    int st = got_n;
    load_lane(0, 2, 9, 3, 0, WORD_A);
    load_lane(1, 5, 9, 3, 3, WORD_A);
    load_lane(2, 0, 9, 3, 6, WORD_A);
    load_lane(3, 3, 9, 3, 2, WORD_A);
    begin_burst(4'hF);
    repeat (90) @(negedge clk);
    chk(hs_locked == 1, "R7", "locked with skew", hs_locked, 1);
    check_beats(st, 9, 4'hF, 3, "R4");
    end_burst();
  endtask

  task automatic t_mask();  // R6
    int st = got_n;
    for (int l = 0; l < 4; l++) load_lane(l, l, 6, 5, l, WORD_A);
    begin_burst(4'b0101);
    repeat (80) @(negedge clk);
    check_beats(st, 6, 4'b0101, 5, "R6");
    end_burst();
  endtask

  task automatic t_backpressure();  // R8
    int st = got_n;
    for (int l = 0; l < 4; l++) load_lane(l, 1, 10, 2, l, WORD_A);
    hold_until = cyc + 100;
    begin_burst(4'hF);
    repeat (60) @(negedge clk);
    chk(out_valid == 1, "R8", "valid held while stalled", out_valid, 1);
    chk(got_n - st == 0, "R8", "no beat taken while stalled", got_n - st, 0);
    repeat (80) @(negedge clk);
    check_beats(st, 10, 4'hF, 2, "R8");
    end_burst();
  endtask

  task automatic t_flush();  // R10
    int st;
    for (int l = 0; l < 4; l++) load_lane(l, 0, 8, 4, 0, WORD_A);
    hold_until = cyc + 1000;
    begin_burst(4'hF);
    repeat (60) @(negedge clk);
    chk(out_valid == 1, "R10", "beat pending before stop", out_valid, 1);
    lp_stop = 1;
    @(negedge clk);
    chk(lp_rx == 1, "R10", "lp_rx one cycle after stop", lp_rx, 1);
    chk(out_valid == 0, "R10", "out_valid after stop", out_valid, 0);
    repeat (20) @(negedge clk);
    hold_until = cyc;
    repeat (10) @(negedge clk);
    st = got_n;
    for (int l = 0; l < 4; l++) load_lane(l, 1, 5, 6, 0, WORD_A);
    begin_burst(4'hF);
    repeat (80) @(negedge clk);
    check_beats(st, 5, 4'hF, 6, "R10");
    end_burst();
  endtask

  task automatic t_settle();  // R3
    int st = got_n;
    cfg_settle = 8'd60;
    for (int l = 0; l < 4; l++) load_lane(l, 0, 4, 0, 0, WORD_A);
    @(negedge clk); lane_en = 4'hF; lp_stop = 0;
    go_cnt++;
    repeat (60 + 200 + 20) @(negedge clk);
    chk(sync_err == 1, "R3", "sync in settle not seen", sync_err, 1);
    chk(got_n - st == 0, "R3", "no beats", got_n - st, 0);
    end_burst();
    cfg_settle = 8'd4;
  endtask

  task automatic t_timeout();  // R9 R2
    int n = 0;
    cfg_sync_timeout = 12'd20;
    for (int l = 0; l < 4; l++) load_lane(l, 0, 3, 0, 0, WORD_A);
    tx_len[2] = 0;
    @(negedge clk); lane_en = 4'hF; lp_stop = 0;
    fork
      begin
        while (n < 300) begin
          @(posedge clk); n++;
          @(negedge clk);
          if (sync_err) break;
        end
      end
      begin repeat (12) @(negedge clk); go_cnt++; end
    join
    chk(n == 4 + 20 + 3, "R9", "edge of sync_err", n, 27);
    chk(lp_rx == 1, "R9", "back in LP", lp_rx, 1);
    repeat (40) @(negedge clk);
    chk(lp_rx == 1, "R2", "no restart while lp_stop low", lp_rx, 1);
    chk(sync_err == 1, "R9", "sync_err sticky", sync_err, 1);
    end_burst();
    cfg_sync_timeout = 12'd200;
  endtask

  task automatic t_enable();  // R2
    hs_rx_en = 0;
    @(negedge clk); lp_stop = 0;
    repeat (15) @(negedge clk);
    chk(lp_rx == 1, "R2", "hs_rx_en low blocks burst", lp_rx, 1);
    chk(sync_err == 1, "R2", "sync_err untouched without start", sync_err, 1);
    @(negedge clk); lp_stop = 1; hs_rx_en = 1;
    repeat (3) @(negedge clk);
    lane_en = 4'h0; lp_stop = 0;
    repeat (15) @(negedge clk);
    chk(lp_rx == 1, "R2", "empty lane mask blocks burst", lp_rx, 1);
    lp_stop = 1;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_word();  // R11
    int st = got_n;
    cfg_sync_word = WORD_B;
    for (int l = 0; l < 4; l++) load_lane(l, 0, 5, 7, 0, WORD_A);
    begin_burst(4'hF);
    repeat (230) @(negedge clk);
    chk(sync_err == 1, "R11", "old word rejected", sync_err, 1);
    chk(got_n - st == 0, "R11", "no beats on old word", got_n - st, 0);
    end_burst();
    st = got_n;
    for (int l = 0; l < 4; l++) load_lane(l, 2, 5, 7, 3 - l, WORD_B);
    begin_burst(4'hF);
    repeat (80) @(negedge clk);
    chk(sync_err == 0, "R11", "sync_err cleared by new burst", sync_err, 0);
    check_beats(st, 5, 4'hF, 7, "R11");
    end_burst();
    cfg_sync_word = WORD_A;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < 4; l++) begin tx_len[l] = 0; tx_dly[l] = 0; end
    rst_n = 0; hs_rx_en = 1; lp_stop = 1; lane_en = 4'hF;
    cfg_settle = 8'd4; cfg_sync_timeout = 12'd200; cfg_sync_word = WORD_A;
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (5) @(negedge clk);
    t_basic();
    t_skew();
    t_mask();
    t_backpressure();
    t_flush();
    t_settle();
    t_timeout();
    t_enable();
    t_word();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule